// File: doc/BRIEF.md
# Atomic 16-bit Timer Register Bridge

This block lets an 8-bit processor bus reach a set of 16-bit timer registers: one free-running counter, a parameterised number of compare registers, and one capture register. A single byte of staging storage, shared by every 16-bit register, makes each 16-bit transfer atomic. Software writes the high byte first, which only fills the staging byte. It then writes the low byte, which commits both bytes to the target register in the same clock edge. For reads of the counter or the capture register, software reads the low byte first; that read also freezes the matching high byte into the staging byte, and the following high-byte read returns the frozen copy. Compare registers change only through writes, so their high bytes are read directly.

The 16-bit storage lives inside the block. The counter advances on a tick input and clears on a clear input. A capture event copies the counter into the capture register. Each committed write also leaves the block as a one-cycle strobe per register, together with the committed 16-bit word, for the timer logic outside.

Top module: `tbridge_top`

## Requirements
- R1: A write to the high-byte address of any mapped register changes only the staging byte: no register changes and no write strobe is raised.
- R2: Register k (k = 0 counter, 1..NUM_CMP compare, NUM_CMP+1 capture) has its low byte at address 2k and its high byte at 2k+1. A write to address 2k loads register k with {staging byte, write data} at that clock edge. After the same edge, bit k of `reg_we` is high for one cycle and `reg_wdata` holds the committed word.
- R3: One high-byte write can serve several low-byte writes to any registers, and each of those writes commits the same stored high byte.
- R4: A read of the counter or capture low byte returns that low byte. At the same edge it copies that register's high byte into the staging byte.
- R5: A read of the counter or capture high byte returns the staging byte, even if the register has moved since the low-byte read.
- R6: Reads of either byte of a compare register return the register contents directly and leave the staging byte unchanged.
- R7: The counter increments on `tick` and goes to zero on `cnt_clr`, and clear wins over tick. A bus write to the counter low byte wins over both in the same cycle.
- R8: `cap_evt` copies the counter value held before that edge into the capture register. A bus write to the capture register wins over the event.
- R9: After reset the staging byte, all registers, `bus_rdata` and `reg_we` are zero. A read of an unmapped address returns 0x00. Read data is registered and appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick | input | 1 | Counter increment |
| cnt_clr | input | 1 | Counter clear |
| cap_evt | input | 1 | Capture event |
| reg_we | output | NUM_CMP+2 | One-cycle commit strobe per register |
| reg_wdata | output | 16 | Word committed by the last low-byte write |
| cnt_value | output | 16 | Current counter value |

## Verification
Every compare register is swept with several computed 16-bit words, written high then low and read back both ways. This separates a correct commit from byte swaps, wrong register selection and stale staging data. The counter is taken across the 0x00FF to 0x0100 boundary between a low-byte and a high-byte read; this tells a frozen high byte apart from a live one. Interleaved compare reads show that they leave the staging byte alone. Simultaneous write, clear, tick and capture strobes pin down the priorities, and a single high-byte write followed by several low-byte writes shows that the staging byte is reused.

// File: rtl/tbridge_pkg.sv
package tbridge_pkg;
  typedef enum logic [1:0] {
    K_CNT  = 2'd0,
    K_CMP  = 2'd1,
    K_CAP  = 2'd2,
    K_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/tbridge_decode.sv
module tbridge_decode
  import tbridge_pkg::*;
#(
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned AW      = $clog2(2*(NUM_CMP+2))
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [AW-2:0] idx,
  output logic          is_hi
);
  localparam int unsigned CAP_IDX = NUM_CMP + 1;

  always_comb begin
    idx   = addr[AW-1:1];
    is_hi = addr[0];
    if (idx == '0)                    kind = K_CNT;
    else if (32'(idx) <= NUM_CMP)     kind = K_CMP;
    else if (32'(idx) == CAP_IDX)     kind = K_CAP;
    else                              kind = K_NONE;
  end
endmodule

// File: rtl/tbridge_temp.sv
module tbridge_temp #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_wr,
  input  logic [DW-1:0] wr_byte,
  input  logic          ld_rd,
  input  logic [DW-1:0] rd_byte,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (ld_wr) q <= wr_byte;
    else if (ld_rd) q <= rd_byte;
  end

  // R5: the staging byte only moves on a high write or a latching low read
  a_r5_temp_holds: assert property (@(posedge clk) disable iff (rst)
    (!ld_wr && !ld_rd) |=> $stable(q));
  // R4: a latching read captures the presented high byte
  a_r4_temp_latch: assert property (@(posedge clk) disable iff (rst)
    (!ld_wr && ld_rd) |=> (q == $past(rd_byte)));
endmodule

// File: rtl/tbridge_counter.sv
module tbridge_counter #(
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic          cap_evt,
  input  logic          wr_cnt,
  input  logic          wr_cap,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] cnt,
  output logic [RW-1:0] cap
);
  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (wr_cnt) cnt <= wdata;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          cap <= '0;
    else if (wr_cap)  cap <= wdata;
    else if (cap_evt) cap <= cnt;
  end

  // R7: a bus write beats clear and tick
  a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt == $past(wdata)));
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && clr) |=> (cnt == '0));
  // R8: capture takes the counter value from before the edge
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    (!wr_cap && cap_evt) |=> (cap == $past(cnt)));
endmodule

// File: rtl/tbridge_top.sv
module tbridge_top
  import tbridge_pkg::*;
#(
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = $clog2(2*(NUM_CMP+2))
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 tick,
  input  logic                 cnt_clr,
  input  logic                 cap_evt,
  output logic [NUM_CMP+1:0]   reg_we,
  output logic [2*DW-1:0]      reg_wdata,
  output logic [2*DW-1:0]      cnt_value
);
  localparam int unsigned RW   = 2 * DW;
  localparam int unsigned NREG = NUM_CMP + 2;

  reg_kind_e     kind;
  logic [AW-2:0] idx;
  logic          is_hi;

  tbridge_decode #(.NUM_CMP(NUM_CMP), .AW(AW)) u_dec (
    .addr(bus_addr), .kind(kind), .idx(idx), .is_hi(is_hi)
  );

  logic          mapped, hi_wr, lo_wr, latch_rd;
  logic [DW-1:0] tmp_q;
  logic [RW-1:0] commit;
  logic [RW-1:0] cnt_q, cap_q, live16;

  assign mapped   = (kind != K_NONE);
  assign hi_wr    = bus_wr && is_hi && mapped;
  assign lo_wr    = bus_wr && !is_hi && mapped;
  assign latch_rd = bus_rd && !is_hi && (kind == K_CNT || kind == K_CAP);
  assign commit   = {tmp_q, bus_wdata};
  assign live16   = (kind == K_CAP) ? cap_q : cnt_q;

  tbridge_temp #(.DW(DW)) u_tmp (
    .clk(clk), .rst(rst),
    .ld_wr(hi_wr), .wr_byte(bus_wdata),
    .ld_rd(latch_rd), .rd_byte(live16[RW-1:DW]),
    .q(tmp_q)
  );

  tbridge_counter #(.RW(RW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(cnt_clr), .cap_evt(cap_evt),
    .wr_cnt(lo_wr && kind == K_CNT), .wr_cap(lo_wr && kind == K_CAP),
    .wdata(commit), .cnt(cnt_q), .cap(cap_q)
  );

  // Compare registers: written only through the bus
  logic [RW-1:0] cmp_q [NUM_CMP];
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)
        cmp_q[g] <= '0;
      else if (lo_wr && kind == K_CMP && 32'(idx) == g + 1)
        cmp_q[g] <= commit;
    end
  end

  logic [RW-1:0] cmp_sel;
  always_comb begin
    cmp_sel = '0;
    for (int i = 0; i < NUM_CMP; i++)
      if (32'(idx) == i + 1) cmp_sel = cmp_q[i];
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    unique case (kind)
      K_CNT, K_CAP: rd_next = is_hi ? tmp_q : live16[DW-1:0];
      K_CMP:        rd_next = is_hi ? cmp_sel[RW-1:DW] : cmp_sel[DW-1:0];
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  logic [NREG-1:0] we_next;
  always_comb begin
    we_next = '0;
    for (int i = 0; i < NREG; i++)
      if (lo_wr && 32'(idx) == i) we_next[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we    <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= we_next;
      if (lo_wr) reg_wdata <= commit;
    end
  end

  assign cnt_value = cnt_q;

  // R1: high-byte writes raise no strobe
  a_r1_hi_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && is_hi) |=> (reg_we == '0));
  // R2: a low-byte write commits staging byte plus data in one strobe
  a_r2_commit: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> ($onehot(reg_we) && reg_wdata == {$past(tmp_q), $past(bus_wdata)}));
  // R6: compare reads leave the staging byte alone
  a_r6_cmp_keeps_temp: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && kind == K_CMP) |=> $stable(tmp_q));
  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && kind == K_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_tbridge_top.sv
`timescale 1ns/1ps
module tb_tbridge_top;
  localparam int NUM_CMP = 3;
  localparam int AW      = 4;
  localparam int NREG    = NUM_CMP + 2;
  localparam logic [AW-1:0] CNT_LO = 4'd0, CNT_HI = 4'd1;
  localparam logic [AW-1:0] CAP_LO = 4'(2*(NUM_CMP+1)), CAP_HI = 4'(2*(NUM_CMP+1)+1);

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0, tick = 0, cnt_clr = 0, cap_evt = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [NREG-1:0] reg_we;
  logic [15:0] reg_wdata, cnt_value;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tbridge_top #(.NUM_CMP(NUM_CMP)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .cnt_clr(cnt_clr),
    .cap_evt(cap_evt), .reg_we(reg_we), .reg_wdata(reg_wdata), .cnt_value(cnt_value)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; one rising edge passes; returns at the next falling edge.
  task automatic op(input logic w, input logic r, input logic [AW-1:0] a, input logic [7:0] d,
                    input logic t, input logic c, input logic e);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    tick = t; cnt_clr = c; cap_evt = e;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tick = 0; cnt_clr = 0; cap_evt = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    op(1, 0, a, d, 0, 0, 0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    op(0, 1, a, 8'h00, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    chk("R9 rdata after reset", 16'(bus_rdata), 16'h0);
    chk("R9 reg_we after reset", 16'(reg_we), 16'h0);
    chk("R9 counter after reset", cnt_value, 16'h0);
    rd(CNT_HI);
    chk("R9 staging byte after reset", 16'(bus_rdata), 16'h0);

    // R2 sweep over compare registers with computed words
    for (int i = 0; i < NUM_CMP; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] v;
        v = 16'((i * 16'h3B17 + k * 16'h1F05) ^ 16'hA5C3);
        wr(4'(3 + 2*i), v[15:8]);
        wr(4'(2 + 2*i), v[7:0]);
        chk("R2 strobe", 16'(reg_we), 16'(1 << (i + 1)));
        chk("R2 committed word", reg_wdata, v);
        rd(4'(2 + 2*i));
        chk("R6 compare low read", 16'(bus_rdata), 16'(v[7:0]));
        rd(4'(3 + 2*i));
        chk("R6 compare high read", 16'(bus_rdata), 16'(v[15:8]));
      end
    end

    // R4/R5 atomic read across 0x00FF -> 0x0100
    wr(CNT_HI, 8'h00);
    wr(CNT_LO, 8'hFF);
    chk("R2 counter strobe", 16'(reg_we), 16'h0001);
    rd(CNT_LO);
    chk("R4 counter low read", 16'(bus_rdata), 16'h00FF);
    op(0, 0, CNT_LO, 8'h00, 1, 0, 0);
    chk("R7 tick increments", cnt_value, 16'h0100);
    rd(CNT_HI);
    chk("R5 high read returns frozen byte", 16'(bus_rdata), 16'h0000);
    rd(CNT_LO);
    chk("R4 counter low after carry", 16'(bus_rdata), 16'h0000);
    // R6 a compare read in between must not disturb the staging byte
    rd(4'd3);
    rd(CNT_HI);
    chk("R6 staging byte kept across compare read", 16'(bus_rdata), 16'h0001);

    // R3 one high write, several low writes
    wr(4'd5, 8'hC7);
    wr(4'd2, 8'h11);
    wr(4'd4, 8'h22);
    wr(4'd6, 8'h33);
    wr(CNT_LO, 8'h44);
    chk("R3 counter reuses high byte", cnt_value, 16'hC744);
    rd(4'd3); chk("R3 compare 1 high", 16'(bus_rdata), 16'h00C7);
    rd(4'd5); chk("R3 compare 2 high", 16'(bus_rdata), 16'h00C7);
    rd(4'd7); chk("R3 compare 3 high", 16'(bus_rdata), 16'h00C7);

    // R1 high write alone changes no register
    wr(4'd5, 8'h5A);
    chk("R1 no strobe on high write", 16'(reg_we), 16'h0);
    rd(4'd5); chk("R1 compare 2 high unchanged", 16'(bus_rdata), 16'h00C7);
    rd(4'd4); chk("R1 compare 2 low unchanged", 16'(bus_rdata), 16'h0022);

    // R7 priorities
    op(1, 0, CNT_LO, 8'h99, 1, 1, 0);
    chk("R7 write beats clear and tick", cnt_value, 16'h5A99);
    op(0, 0, CNT_LO, 8'h00, 1, 1, 0);
    chk("R7 clear beats tick", cnt_value, 16'h0000);
    op(0, 0, CNT_LO, 8'h00, 1, 0, 0);
    chk("R7 tick from zero", cnt_value, 16'h0001);

    // R8 capture
    wr(CNT_HI, 8'h12);
    wr(CNT_LO, 8'h34);
    op(0, 0, CNT_LO, 8'h00, 1, 0, 1);
    chk("R8 counter advanced with capture", cnt_value, 16'h1235);
    rd(CAP_LO); chk("R8 capture low", 16'(bus_rdata), 16'h0034);
    rd(CAP_HI); chk("R8 capture high via staging", 16'(bus_rdata), 16'h0012);
    wr(CAP_HI, 8'h9E);
    op(1, 0, CAP_LO, 8'h01, 0, 0, 1);
    chk("R8 capture write strobe", 16'(reg_we), 16'(1 << (NUM_CMP + 1)));
    rd(CAP_LO); chk("R8 write beats event low", 16'(bus_rdata), 16'h0001);
    rd(CAP_HI); chk("R8 write beats event high", 16'(bus_rdata), 16'h009E);

    // R9 unmapped reads with a non-zero staging byte
    for (int a = 2*NREG; a < 16; a++) begin
      rd(4'(a));
      chk("R9 unmapped read", 16'(bus_rdata), 16'h0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule